// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns the address a device presents for a DMA transfer into a physical memory address. It looks the address up in a single-level page table kept in main memory. The table is described by two registers that software writes: a base pointer and a length. The length is counted in bytes of table, not in entries. The logical address is split into a page number and an in-page offset, using 4 KiB pages by default. The page number is checked against the number of whole entries the table length covers. If it is in range, the entry is read through a simple memory read port.

Each table entry is 8 bytes long. The low word holds the frame and the high word holds the owner. Only the frame word is used: its page bits are combined with the untouched offset of the logical address. The outcome is one of two things. Either it is a translated address, which carries read/write permission. Or it is a fault with no permission: this happens when the page number is out of range or when the memory answers the entry read with an error. The top bit of the table base is masked off before the entry address is formed.

The walker serves one request at a time. It drops its ready signal from the moment it accepts a request until it has reported the result. It keeps no copies of entries, so an invalidate strobe is accepted and changes nothing.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` and `mem_rd_valid` are 0, and both the table base and the table length read as 0, so the first request faults.
- R2: The page number is `req_addr >> 12`. A request whose page number is not less than `length >> 3` reports `res_valid` with `res_fault` = 1 in the cycle after acceptance and issues no memory read.
- R3: The entry read address is `(base & 0x7FFFFFFF) + page*8`, modulo 2^32, so a base with bit 31 set reads the same entry as the base with that bit cleared.
- R4: On a successful entry read, `res_addr` = `{frame[31:12], req_addr[11:0]}` with `res_fault` = 0. The frame is `mem_rsp_data[31:0]`, and the owner word in `mem_rsp_data[63:32]` has no effect on the result.
- R5: An entry read answered with `mem_rsp_err` = 1 reports `res_fault` = 1, and every fault reports `res_addr` = 0.
- R6: After a request is accepted, `req_ready` is 0 until the result is reported. `res_valid` is high for exactly one cycle per accepted request, and results come back in request order.
- R7: Once raised, `mem_rd_valid` stays high with `mem_rd_addr` unchanged until the cycle in which `mem_rd_ready` is 1.
- R8: Pulses on `inval_strobe` have no effect on any result or on the memory reads issued.
- R9: The length is truncated to whole entries. A length of 0x47 admits pages 0 to 7 only, and a length of 0x48 also admits page 8.
- R10: A configuration write with `cfg_sel` = 0 loads the base and with `cfg_sel` = 1 loads the length. It takes effect for requests accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfg_wdata | input | ADDR_W | Configuration write data |
| inval_strobe | input | 1 | Invalidate request, accepted and ignored |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | ADDR_W | Logical DMA address |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the entry read |
| mem_rd_addr | output | ADDR_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_err | input | 1 | Entry read failed |
| mem_rsp_data | input | 2*ADDR_W | Entry: frame in low half, owner in high half |
| res_valid | output | 1 | Result strobe, one cycle |
| res_fault | output | 1 | Result denies access |
| res_addr | output | ADDR_W | Translated physical address, 0 on fault |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, 4 KiB pages, 8-byte entries and the base top-bit mask enabled. With 32-bit addresses the full 20-bit page number is exercised, up to page 0xFFFFF with a table length near 4 GiB. Enabling the mask lets a base of 0xEE000000 be shown to read the same entries as 0x6E000000. The 12-bit offset width puts the page-boundary cases, at lengths 0x40, 0x47 and 0x48, on easily computed values. A memory model whose ready and response delays cycle through 0 to 2 checks the read hold rule under stalls, and a varying owner word checks that it is ignored.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

   typedef enum logic [1:0] {
      XW_IDLE = 2'd0,
      XW_REQ  = 2'd1,
      XW_WAIT = 2'd2,
      XW_DONE = 2'd3
   } xw_state_e;

   localparam logic XW_SEL_BASE  = 1'b0;
   localparam logic XW_SEL_LIMIT = 1'b1;

endpackage

// File: rtl/xw_cfg_regs.sv
module xw_cfg_regs #(
   parameter int ADDR_W   = 32,
   parameter bit MASK_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base_eff,
   output logic [ADDR_W-1:0] limit
);
   import dma_xlate_pkg::*;

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] limit_q;
   logic [ADDR_W-1:0] base_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (we) begin
         if (sel == XW_SEL_BASE) base_q  <= wdata;
         else                    limit_q <= wdata;
      end
   end

   generate
      if (MASK_TOP) begin : g_mask
         assign base_mask = {1'b0, {(ADDR_W-1){1'b1}}};
      end else begin : g_nomask
         assign base_mask = {ADDR_W{1'b1}};
      end
   endgenerate

   assign base_eff = base_q & base_mask;
   assign limit    = limit_q;

   // R1: registers clear on reset
   assert_cfg_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (limit == '0 && base_eff == '0));

endmodule

// File: rtl/xw_range_check.sv
module xw_range_check #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3
) (
   input  logic [ADDR_W-PAGE_SHIFT-1:0] page,
   input  logic [ADDR_W-1:0]            base_eff,
   input  logic [ADDR_W-1:0]            limit,
   output logic                         hit,
   output logic [ADDR_W-1:0]            ent_addr
);
   localparam int IDX_W = ADDR_W - PAGE_SHIFT;

   logic [ADDR_W-1:0] idx_ext;
   logic [ADDR_W-1:0] lim_entries;

   always_comb begin
      idx_ext     = {{PAGE_SHIFT{1'b0}}, page};
      lim_entries = limit >> ENTRY_SHIFT;
      hit         = (idx_ext < lim_entries);
      ent_addr    = base_eff + (idx_ext << ENTRY_SHIFT);
   end

   generate
      if (IDX_W < 1) begin : g_bad_idx
         $error("xw_range_check: page index width must be positive");
      end
   endgenerate

endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [PAGE_SHIFT-1:0]        req_off,
   input  logic                         hit,
   input  logic [ADDR_W-1:0]            ent_addr,
   output logic                         mem_rd_valid,
   input  logic                         mem_rd_ready,
   output logic [ADDR_W-1:0]            mem_rd_addr,
   input  logic                         mem_rsp_valid,
   input  logic                         mem_rsp_err,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] frame_page,
   output logic                         res_valid,
   output logic                         res_fault,
   output logic [ADDR_W-1:0]            res_addr
);
   import dma_xlate_pkg::*;

   xw_state_e             state_q;
   logic [PAGE_SHIFT-1:0] off_q;
   logic [ADDR_W-1:0]     ent_q;
   logic                  fault_q;
   logic [ADDR_W-1:0]     pa_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XW_IDLE;
         off_q   <= '0;
         ent_q   <= '0;
         fault_q <= 1'b0;
         pa_q    <= '0;
      end else begin
         unique case (state_q)
            XW_IDLE: if (req_valid) begin
               off_q <= req_off;
               ent_q <= ent_addr;
               if (hit) begin
                  state_q <= XW_REQ;
               end else begin
                  fault_q <= 1'b1;
                  pa_q    <= '0;
                  state_q <= XW_DONE;
               end
            end
            XW_REQ: if (mem_rd_ready) state_q <= XW_WAIT;
            XW_WAIT: if (mem_rsp_valid) begin
               fault_q <= mem_rsp_err;
               pa_q    <= mem_rsp_err ? '0 : {frame_page, off_q};
               state_q <= XW_DONE;
            end
            XW_DONE: state_q <= XW_IDLE;
            default: state_q <= XW_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == XW_IDLE);
   assign mem_rd_valid = (state_q == XW_REQ);
   assign mem_rd_addr  = ent_q;
   assign res_valid    = (state_q == XW_DONE);
   assign res_fault    = fault_q;
   assign res_addr     = pa_q;

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   assert_one_at_a_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_res_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_miss_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !hit) |=> (res_valid && res_fault && !mem_rd_valid));

   assert_err_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XW_WAIT && mem_rsp_valid && mem_rsp_err) |=> (res_valid && res_fault));

   assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault) |-> (res_addr == '0));

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
   parameter int ADDR_W      = 32,
   parameter int PAGE_SHIFT  = 12,
   parameter int ENTRY_SHIFT = 3,
   parameter bit MASK_TOP    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_sel,
   input  logic [ADDR_W-1:0]   cfg_wdata,
   input  logic                inval_strobe,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   output logic                mem_rd_valid,
   input  logic                mem_rd_ready,
   output logic [ADDR_W-1:0]   mem_rd_addr,
   input  logic                mem_rsp_valid,
   input  logic                mem_rsp_err,
   input  logic [2*ADDR_W-1:0] mem_rsp_data,
   output logic                res_valid,
   output logic                res_fault,
   output logic [ADDR_W-1:0]   res_addr
);
   localparam int IDX_W = ADDR_W - PAGE_SHIFT;

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_chk_page
         $error("dma_xlate_walker: PAGE_SHIFT out of range");
      end
      if (ENTRY_SHIFT < 1 || ENTRY_SHIFT >= PAGE_SHIFT) begin : g_chk_entry
         $error("dma_xlate_walker: ENTRY_SHIFT out of range");
      end
      if ((1 << ENTRY_SHIFT) != (2 * ADDR_W) / 8) begin : g_chk_size
         $error("dma_xlate_walker: entry size must hold frame and owner words");
      end
   endgenerate

   logic [ADDR_W-1:0] base_eff;
   logic [ADDR_W-1:0] limit;
   logic              hit;
   logic [ADDR_W-1:0] ent_addr;
   logic              unused_owner_and_inval;

   assign unused_owner_and_inval = ^{mem_rsp_data[2*ADDR_W-1:ADDR_W],
                                     mem_rsp_data[PAGE_SHIFT-1:0], inval_strobe};

   xw_cfg_regs #(.ADDR_W(ADDR_W), .MASK_TOP(MASK_TOP)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .base_eff (base_eff),
      .limit    (limit)
   );

   xw_range_check #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                    .ENTRY_SHIFT(ENTRY_SHIFT)) u_range (
      .page     (req_addr[ADDR_W-1:PAGE_SHIFT]),
      .base_eff (base_eff),
      .limit    (limit),
      .hit      (hit),
      .ent_addr (ent_addr)
   );

   xw_walk_fsm #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_off       (req_addr[PAGE_SHIFT-1:0]),
      .hit           (hit),
      .ent_addr      (ent_addr),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_err   (mem_rsp_err),
      .frame_page    (mem_rsp_data[ADDR_W-1:PAGE_SHIFT]),
      .res_valid     (res_valid),
      .res_fault     (res_fault),
      .res_addr      (res_addr)
   );

   // R1: idle and quiet straight after reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !res_valid && !mem_rd_valid));

   logic [IDX_W-1:0] unused_idx_w_probe;
   assign unused_idx_w_probe = req_addr[ADDR_W-1:PAGE_SHIFT];

endmodule

// File: tb/dma_xlate_walker_tb.sv
module dma_xlate_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_sel, inval_strobe;
   logic [31:0] cfg_wdata;
   logic        req_valid, req_ready;
   logic [31:0] req_addr;
   logic        mem_rd_valid, mem_rd_ready;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid, mem_rsp_err;
   logic [63:0] mem_rsp_data;
   logic        res_valid, res_fault;
   logic [31:0] res_addr;

   int checks = 0;
   int errors = 0;
   logic [32:0] exp_q[$];
   logic [31:0] ent_q[$];
   logic [31:0] sh_base = '0;
   logic [31:0] sh_limit = '0;
   logic [31:0] owner_salt = '0;
   bit          inval_on = 1'b0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dma_xlate_walker u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .inval_strobe(inval_strobe),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_fault(res_fault), .res_addr(res_addr));

   function automatic logic [31:0] frame_of(input logic [31:0] a);
      return {a[19:0] ^ 20'hA5C3F, 12'hABC};
   endfunction

   function automatic logic bad_ent(input logic [31:0] a);
      return a[31:24] == 8'h6E;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) sh_limit = d; else sh_base = d;
   endtask

   // driver: computes the expected result from the requirements and queues it
   task automatic xlate(input logic [31:0] la);
      logic [31:0] idx, ent, fr;
      logic        hit;
      idx = la >> 12;
      hit = idx < (sh_limit >> 3);
      ent = (sh_base & 32'h7FFF_FFFF) + (idx << 3);
      if (hit) begin
         ent_q.push_back(ent);
         fr = frame_of(ent);
         if (bad_ent(ent)) exp_q.push_back({1'b1, 32'h0});
         else              exp_q.push_back({1'b0, fr[31:12], la[11:0]});
      end else begin
         exp_q.push_back({1'b1, 32'h0});
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = la;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R6 busy after accept", {63'h0, req_ready}, 64'h0);
      if (!hit)
         chk(res_valid && res_fault && !mem_rd_valid, "R2 miss faults next cycle, no read",
             {61'h0, res_valid, res_fault, mem_rd_valid}, 64'h6);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected result", {31'h0, res_fault, res_addr}, 64'h0);
            end else begin
               logic [32:0] e;
               e = exp_q.pop_front();
               chk({res_fault, res_addr} == e, "R2/R3/R4/R5/R9 result",
                   {31'h0, res_fault, res_addr}, {31'h0, e});
            end
         end
      end
   end

   // memory model with cycling delays
   initial begin
      int rdy_dly = 0;
      int rsp_dly = 0;
      logic [31:0] a;
      mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mem_rd_valid) begin
            a = mem_rd_addr;
            for (int k = 0; k < rdy_dly; k++) begin
               @(negedge clk);
               chk(mem_rd_valid && mem_rd_addr == a, "R7 read held while stalled",
                   {31'h0, mem_rd_valid, mem_rd_addr}, {31'h0, 1'b1, a});
            end
            mem_rd_ready = 1'b1;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            if (ent_q.size() == 0) begin
               chk(1'b0, "R3 unexpected entry read", {32'h0, a}, 64'h0);
            end else begin
               logic [31:0] e;
               e = ent_q.pop_front();
               chk(a == e, "R3 entry address", {32'h0, a}, {32'h0, e});
            end
            for (int k = 0; k < rsp_dly; k++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = bad_ent(a);
            mem_rsp_data  = {~a ^ owner_salt, frame_of(a)};
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            mem_rsp_data  = {$urandom(), $urandom()};
            rdy_dly = (rdy_dly + 1) % 3;
            rsp_dly = (rsp_dly + 2) % 3;
         end
      end
   end

   // R8 stimulus: invalidate pulses while enabled
   initial begin
      inval_strobe = 1'b0;
      forever begin
         @(negedge clk);
         inval_strobe = inval_on ? ~inval_strobe : 1'b0;
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      req_valid = 1'b0; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(req_ready && !res_valid && !mem_rd_valid, "R1 reset outputs",
          {61'h0, req_ready, res_valid, mem_rd_valid}, 64'h4);
      xlate(32'h0000_0123);                 // R1: length 0 faults

      // R10: base and length loaded by select
      cfg_write(1'b0, 32'h0001_0000);
      cfg_write(1'b1, 32'h0000_0040);       // 8 entries
      xlate(32'h0000_0ABC);                 // R4 page 0
      xlate(32'h0000_3F01);                 // page 3
      xlate(32'h0000_7FFF);                 // page 7, last
      xlate(32'h0000_8000);                 // R2 page 8 faults

      // R9: truncation of the length
      cfg_write(1'b1, 32'h0000_0047);
      xlate(32'h0000_8001);                 // R9 still faults
      xlate(32'h0000_7002);
      cfg_write(1'b1, 32'h0000_0048);
      xlate(32'h0000_8003);                 // R9 now hits

      // R3: top bit of base masked
      cfg_write(1'b0, 32'h8002_0000);
      xlate(32'h0000_2345);
      // R5: memory error, and R3 masking of 0xEE.. onto the erroring 0x6E.. region
      cfg_write(1'b0, 32'h6E00_0000);
      xlate(32'h0000_1111);
      cfg_write(1'b0, 32'hEE00_0000);
      xlate(32'h0000_4444);

      // R3: widest page index
      cfg_write(1'b0, 32'h7FFF_0000);
      cfg_write(1'b1, 32'hFFFF_FFF8);
      xlate(32'hFFFF_F123);
      xlate(32'h1234_5678);

      // R4: owner word ignored, R8: invalidate ignored
      cfg_write(1'b0, 32'h0003_0000);
      owner_salt = 32'h0;
      xlate(32'h0000_5A5A);
      owner_salt = 32'hDEAD_BEEF;
      xlate(32'h0000_5A5A);
      inval_on = 1'b1;
      xlate(32'h0000_5A5A);
      xlate(32'h0000_6001);
      inval_on = 1'b0;

      // R6: back-to-back requests keep order
      for (int i = 0; i < 6; i++) xlate(32'h0000_1000 * i + i);

      for (int w = 0; w < 200 && (exp_q.size() != 0 || ent_q.size() != 0); w++)
         @(negedge clk);
      chk(exp_q.size() == 0, "R6 all results returned", {32'h0, exp_q.size()}, 64'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule